// File: doc/BRIEF.md
# Control-dependent untestable path monitor

This block observes the control signals that a controller sends to a data path, one controller state at a time. It judges whether one register-transfer path between a start register and an end register can ever carry a value in a single clock. A path is exercised when two directly consecutive controller states meet three conditions. In the earlier state the start register loads, which launches a value. In the later state the end register loads, which captures it. Also in the later state, every multiplexer along the path selects the input that lies on the path.

The monitor keeps the earlier state's launch condition in a one-entry history. It evaluates each new state against that history and records any qualifying pair in a sticky flag. When the analysis window ends and the flag is still low, the path is reported untestable and can be left out of delay test generation.

A register without a hold function has no load-enable choice, so its hold-capability input is tied low and its enable is then taken as permanently asserted. A primary input at the path start, or a primary output at the path end, is handled the same way.

Top module: `cup_path_monitor`

## Requirements
- R1: After reset, `exercised_o` and `untestable_o` are both 0.
- R2: A state is a cycle with `state_vld_i` high. Only two directly consecutive states form a pair, and cycles with `state_vld_i` low between them do not break the pairing. The first state after reset or clear can never qualify on its own.
- R3: A pair is disqualified when the effective start load enable is 0 in the earlier state, whatever the later state holds. The start enable in the later state has no effect on that pair.
- R4: A pair is disqualified when the effective end load enable is 0 in the later state, whatever the earlier state holds. The end enable in the earlier state has no effect on that pair.
- R5: A pair is disqualified when any unmasked multiplexer's select differs from its expected value in the later state. Select values in the earlier state are ignored, and multiplexers whose mask bit is 0 are ignored.
- R6: With `start_hold_i` = 0 the start enable is taken as 1, whatever `start_le_i` is. With `end_hold_i` = 0 the end enable is taken as 1, whatever `end_le_i` is.
- R7: A qualifying pair sets `exercised_o` one clock after the edge that samples the later state. The flag then stays 1 until a clear.
- R8: `clear_i` is synchronous. On the next edge it zeroes `exercised_o`, `untestable_o` and the stored previous state, and it overrides every other input.
- R9: On an edge with `analysis_end_i` high, `untestable_o` becomes 1 if no qualifying pair has been seen, counting a pair completed on that same edge, and becomes 0 otherwise. A later qualifying pair drops `untestable_o` to 0, so the two outputs are never both 1.
- R10: Multiplexer k uses bits [2k+1:2k] of `mux_sel_i` and `mux_exp_i` and bit k of `mux_msk_i`. Both bits of each select field are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of flag, verdict and history |
| state_vld_i | input | 1 | Strobe marking a new controller state |
| start_hold_i | input | 1 | Start register has a hold function |
| start_le_i | input | 1 | Start register load enable in this state |
| end_hold_i | input | 1 | End register has a hold function |
| end_le_i | input | 1 | End register load enable in this state |
| mux_sel_i | input | 16 | Select value of each multiplexer on the path, 2 bits each |
| mux_exp_i | input | 16 | Select value that routes the path, per multiplexer |
| mux_msk_i | input | 8 | Multiplexer k takes part when bit k is 1 |
| analysis_end_i | input | 1 | End of analysis window, requests a verdict |
| exercised_o | output | 1 | Sticky: a qualifying state pair was seen |
| untestable_o | output | 1 | Verdict: path never exercised by the analysis end |

## Verification
`exercised_o` changes in the cycle after the clock edge that samples the second state of a qualifying pair. `untestable_o` changes in the cycle after the edge that samples `analysis_end_i`. Every stimulus is driven on a falling edge and held for exactly one rising edge. Each check reads the output on the falling edge that follows that rising edge, which is the first point where the registered result is settled. Cases that test whether an input is ignored also read `exercised_o` at that same falling edge, where any effect of the ignored input would already be visible.

// File: rtl/cup_pkg.sv
package cup_pkg;
  localparam int unsigned MUX_N_DEF = 8;
  localparam int unsigned SEL_W_DEF = 2;

  typedef struct packed {
    logic vld;
    logic launch;
  } prev_st_t;
endpackage

// File: rtl/cup_route_chk.sv
module cup_route_chk #(
  parameter int unsigned MUX_N = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic [MUX_N*SEL_W-1:0] sel_i,
  input  logic [MUX_N*SEL_W-1:0] exp_i,
  input  logic [MUX_N-1:0]       msk_i,
  output logic                   routed_o
);
  logic [MUX_N-1:0] ok;

  for (genvar k = 0; k < MUX_N; k++) begin : g_mux
    assign ok[k] = !msk_i[k] || (sel_i[k*SEL_W +: SEL_W] == exp_i[k*SEL_W +: SEL_W]);
  end

  assign routed_o = &ok;
endmodule

// File: rtl/cup_pair_trk.sv
module cup_pair_trk
  import cup_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clear_i,
  input  logic     state_vld_i,
  input  logic     launch_i,
  output prev_st_t prev_o
);
  prev_st_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else if (clear_i) begin
      prev_q <= '0;
    end else if (state_vld_i) begin
      prev_q.vld    <= 1'b1;
      prev_q.launch <= launch_i;
    end
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/cup_verdict.sv
module cup_verdict (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic hit_i,
  input  logic analysis_end_i,
  output logic exercised_o,
  output logic untestable_o
);
  logic flag_q, untst_q;
  logic flag_d;

  assign flag_d = flag_q | hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      untst_q <= 1'b0;
    end else if (clear_i) begin
      flag_q  <= 1'b0;
      untst_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (analysis_end_i) untst_q <= !flag_d;
      else if (hit_i)     untst_q <= 1'b0;
    end
  end

  assign exercised_o  = flag_q;
  assign untestable_o = untst_q;
endmodule

// File: rtl/cup_path_monitor.sv
module cup_path_monitor
  import cup_pkg::*;
#(
  parameter int unsigned MUX_N = MUX_N_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   state_vld_i,
  input  logic                   start_hold_i,
  input  logic                   start_le_i,
  input  logic                   end_hold_i,
  input  logic                   end_le_i,
  input  logic [MUX_N*SEL_W-1:0] mux_sel_i,
  input  logic [MUX_N*SEL_W-1:0] mux_exp_i,
  input  logic [MUX_N-1:0]       mux_msk_i,
  input  logic                   analysis_end_i,
  output logic                   exercised_o,
  output logic                   untestable_o
);
  logic     launch, capture, routed, hit;
  prev_st_t prev;

  // no hold function: register loads every state
  assign launch  = start_le_i | ~start_hold_i;
  assign capture = end_le_i   | ~end_hold_i;

  cup_route_chk #(.MUX_N(MUX_N), .SEL_W(SEL_W)) u_route (
    .sel_i    (mux_sel_i),
    .exp_i    (mux_exp_i),
    .msk_i    (mux_msk_i),
    .routed_o (routed)
  );

  cup_pair_trk u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .state_vld_i (state_vld_i),
    .launch_i    (launch),
    .prev_o      (prev)
  );

  assign hit = state_vld_i & prev.vld & prev.launch & capture & routed;

  cup_verdict u_vrd (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (clear_i),
    .hit_i          (hit),
    .analysis_end_i (analysis_end_i),
    .exercised_o    (exercised_o),
    .untestable_o   (untestable_o)
  );
endmodule

// File: rtl/cup_path_monitor_chk.sv
module cup_path_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_i,
  input logic state_vld_i,
  input logic end_hold_i,
  input logic end_le_i,
  input logic analysis_end_i,
  input logic routed_i,
  input logic exercised_o,
  input logic untestable_o
);
  AST_STICKY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exercised_o && !clear_i |=> exercised_o); // R7

  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !exercised_o && !untestable_o); // R8

  AST_RISE_NEEDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exercised_o) |-> $past(state_vld_i)); // R2

  AST_RISE_NEEDS_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exercised_o) |-> $past(end_le_i || !end_hold_i)); // R4

  AST_RISE_NEEDS_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exercised_o) |-> $past(routed_i)); // R5

  AST_VERDICT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exercised_o && untestable_o)); // R9

  AST_VERDICT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    analysis_end_i && !clear_i && !exercised_o && !state_vld_i |=> untestable_o); // R9
endmodule

bind cup_path_monitor cup_path_monitor_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clear_i        (clear_i),
  .state_vld_i    (state_vld_i),
  .end_hold_i     (end_hold_i),
  .end_le_i       (end_le_i),
  .analysis_end_i (analysis_end_i),
  .routed_i       (routed),
  .exercised_o    (exercised_o),
  .untestable_o   (untestable_o)
);

// File: tb/sim_cup_path_monitor.sv
`timescale 1ns/1ps
module sim_cup_path_monitor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        state_vld_i = 1'b0;
  logic        start_hold_i = 1'b1;
  logic        start_le_i = 1'b0;
  logic        end_hold_i = 1'b1;
  logic        end_le_i = 1'b0;
  logic [15:0] mux_sel_i = '0;
  logic [15:0] mux_exp_i = 16'hC6A3;
  logic [7:0]  mux_msk_i = 8'hFF;
  logic        analysis_end_i = 1'b0;
  logic        exercised_o, untestable_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  cup_path_monitor u0 (.*);

  typedef struct packed {
    logic        s_hold;
    logic        s_le;
    logic        e_hold;
    logic        e_le;
    logic [15:0] sel1;
    logic [15:0] sel2;
    logic [7:0]  msk;
    logic        hit;
  } vec_t;

  localparam logic [15:0] EXP = 16'hC6A3;
  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, EXP,      EXP,      8'hFF, 1'b1}, // R7 plain pass
    '{1'b1, 1'b0, 1'b1, 1'b1, EXP,      EXP,      8'hFF, 1'b0}, // R3
    '{1'b1, 1'b1, 1'b1, 1'b0, EXP,      EXP,      8'hFF, 1'b0}, // R4
    '{1'b1, 1'b1, 1'b1, 1'b1, EXP,      16'hCAA3, 8'hFF, 1'b0}, // R5 mux5 wrong
    '{1'b1, 1'b1, 1'b1, 1'b1, EXP,      16'hCAA3, 8'hDF, 1'b1}, // R5 mux5 masked
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'h395C, EXP,      8'hFF, 1'b1}, // R5 first-state sels ignored
    '{1'b0, 1'b0, 1'b1, 1'b1, EXP,      EXP,      8'hFF, 1'b1}, // R6 start no hold
    '{1'b1, 1'b1, 1'b0, 1'b0, EXP,      EXP,      8'hFF, 1'b1}, // R6 end no hold
    '{1'b1, 1'b1, 1'b1, 1'b1, EXP,      16'h46A3, 8'hFF, 1'b0}, // R10 mux7 high bit
    '{1'b1, 1'b1, 1'b1, 1'b1, EXP,      16'h1234, 8'h00, 1'b1}  // R10 all masked
  };

  function automatic string tag(input int i);
    case (i)
      1: return "R3";
      2: return "R4";
      3, 4, 5: return "R5";
      6, 7: return "R6";
      8, 9: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
  endtask

  task automatic state(input logic sle, input logic ele, input logic [15:0] sel);
    @(negedge clk_i);
    state_vld_i = 1'b1; start_le_i = sle; end_le_i = ele; mux_sel_i = sel;
    @(negedge clk_i);
    state_vld_i = 1'b0;
  endtask

  task automatic end_window();
    @(negedge clk_i); analysis_end_i = 1'b1;
    @(negedge clk_i); analysis_end_i = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", exercised_o, 1'b0);
    check("R1", untestable_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: earlier state drives the opposite end enable, later state the opposite start enable
    for (int i = 0; i < NV; i++) begin
      pulse_clear();
      start_hold_i = TBL[i].s_hold; end_hold_i = TBL[i].e_hold; mux_msk_i = TBL[i].msk;
      state(TBL[i].s_le, ~TBL[i].e_le, TBL[i].sel1);
      state(~TBL[i].s_le, TBL[i].e_le, TBL[i].sel2);
      check(tag(i), exercised_o, TBL[i].hit);
      end_window();
      check("R9", untestable_o, !TBL[i].hit);
    end
    start_hold_i = 1'b1; end_hold_i = 1'b1; mux_msk_i = 8'hFF;

    // R2: single state after clear never qualifies
    pulse_clear();
    state(1'b1, 1'b1, EXP);
    check("R2", exercised_o, 1'b0);
    // R2: idle gap does not break pairing
    repeat (3) @(negedge clk_i);
    state(1'b1, 1'b1, EXP);
    check("R2", exercised_o, 1'b1);

    // R2: only consecutive pairs; (A,B) fails on launch, (B,C) passes
    pulse_clear();
    state(1'b0, 1'b1, EXP);
    state(1'b1, 1'b1, 16'h0000);
    check("R2", exercised_o, 1'b0);
    state(1'b0, 1'b1, EXP);
    check("R2", exercised_o, 1'b1);
    // R7 sticky across failing pairs
    state(1'b0, 1'b0, 16'h0000);
    state(1'b0, 1'b0, 16'h0000);
    check("R7", exercised_o, 1'b1);

    // R8 clear zeroes flag and history
    pulse_clear();
    check("R8", exercised_o, 1'b0);
    state(1'b1, 1'b1, EXP);
    check("R8", exercised_o, 1'b0);

    // R9: hit on same edge as analysis end yields not untestable
    @(negedge clk_i);
    state_vld_i = 1'b1; start_le_i = 1'b1; end_le_i = 1'b1; mux_sel_i = EXP; analysis_end_i = 1'b1;
    @(negedge clk_i);
    state_vld_i = 1'b0; analysis_end_i = 1'b0;
    check("R9", untestable_o, 1'b0);
    check("R9", exercised_o, 1'b1);

    // R9: verdict set, then dropped by a later hit
    pulse_clear();
    end_window();
    check("R9", untestable_o, 1'b1);
    state(1'b1, 1'b1, EXP);
    state(1'b1, 1'b1, EXP);
    check("R9", untestable_o, 1'b0);
    check("R9", exercised_o, 1'b1);
    // R8 clear also zeroes verdict
    end_window();
    pulse_clear();
    end_window();
    pulse_clear();
    check("R8", untestable_o, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule